// File: doc/BRIEF.md
# CMI Line Decoder

This block turns a coded-mark-inversion symbol stream into plain NRZ bits. The symbol stream arrives as half-bit samples, one per accepted input beat, so every bit occupies two consecutive samples. The block pairs the samples and decodes each pair. A zero is the pair low-then-high. A one is a pair of equal levels, and the level of successive ones must alternate. Each decoded bit carries a violation flag, which is raised for a bad zero symbol (high-then-low, a transition in mid-bit) or for a one that repeats the level of the previous one.

A mode input selects between CMI decoding and NRZ pass-through. In pass-through every input sample is one bit and appears one register later. A loss-of-signal input holds the data output low while it is active. The sample pairing assumes that the first accepted sample after reset, or after a return to CMI mode, is the first half of a bit.

Both stream edges use valid/ready. An input beat moves when `smp_valid` and `smp_ready` are both high. An output beat moves when `bit_valid` and `bit_ready` are both high. `smp_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops intake. While the consumer stalls, the presented bit and flag stay frozen.

Top module: `cmi_line_decoder`

## Requirements
- R1: After reset `bit_valid` is low, `smp_ready` is high, the pairing starts on a first half, and no alternation reference is held.
- R2: In CMI mode (`cmi_en`=1), the sample pair 0 then 1 decodes to bit 0 with the violation flag low.
- R3: In CMI mode, a pair of equal samples decodes to bit 1. Its flag is high when its level equals the level of the previous one.
- R4: In CMI mode, the pair 1 then 0 decodes to bit 0 with the violation flag high.
- R5: The first one after reset sets the alternation reference and is not flagged.
- R6: Every one, flagged or not, becomes the new alternation reference, so an isolated repeat gives a single flag.
- R7: In CMI mode exactly one output beat is produced per sample pair. Its data and flag are presented together, in the cycle after the second sample is accepted.
- R8: In NRZ mode (`cmi_en`=0), every accepted sample gives one output beat, one cycle later, with data equal to the sample and the flag low.
- R9: While `los` is high, `bit_data` is low. Valid, the flag and the stored bit are not changed by it.
- R10: While `bit_valid` is high and `bit_ready` is low, `smp_ready` is low, no sample is taken, and `bit_data`/`bit_viol` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmi_en | input | 1 | 1 = CMI decoding, 0 = NRZ pass-through |
| los | input | 1 | Loss of signal; forces `bit_data` low |
| smp_valid | input | 1 | Half-bit sample present |
| smp_ready | output | 1 | Block can take a sample |
| smp_data | input | 1 | Half-bit sample level |
| bit_valid | output | 1 | Decoded bit present |
| bit_ready | input | 1 | Consumer takes the bit |
| bit_data | output | 1 | Decoded bit |
| bit_viol | output | 1 | Line code violation in this bit |

## Verification
The block has no tunable parameters, so the bench builds its only configuration. This configuration is small enough to sweep every sequence of four symbol pairs from reset, which is 256 streams. The sweep covers every ordering of good zeros, bad zeros and ones of either level. That reaches the first-one rule, repeated-level flags and the update of the reference after an error. Separate sweeps cover every 8-bit pattern in pass-through and a stall held while loss of signal toggles.

// File: rtl/cmi_dec_pkg.sv
package cmi_dec_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO     = 2'b00,
    SYM_ONE      = 2'b01,
    SYM_BAD_ZERO = 2'b10
  } sym_kind_e;

  function automatic sym_kind_e classify(input logic first_h, input logic second_h);
    if (first_h == second_h) return SYM_ONE;
    else if (!first_h)       return SYM_ZERO;
    else                     return SYM_BAD_ZERO;
  endfunction
endpackage

// File: rtl/cmi_pair_collect.sv
module cmi_pair_collect (
  input  logic clk,
  input  logic rst_n,
  input  logic cmi_en,
  input  logic take,
  input  logic sample,
  output logic pair_fire,
  output logic first_half
);
  logic phase_q;
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (!cmi_en) begin
      phase_q <= 1'b0;
    end else if (take) begin
      if (!phase_q) begin
        first_q <= sample;
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  assign pair_fire  = take && cmi_en && phase_q;
  assign first_half = first_q;

  // R7
  pair_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmi_en && !phase_q) |=> (phase_q && first_q == $past(sample)));
endmodule

// File: rtl/cmi_sym_judge.sv
module cmi_sym_judge
  import cmi_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic first_h,
  input  logic second_h,
  output logic bit_o,
  output logic viol_o
);
  sym_kind_e kind;
  logic      have_ref_q;
  logic      ref_lvl_q;

  always_comb begin
    kind   = classify(first_h, second_h);
    bit_o  = (kind == SYM_ONE);
    viol_o = 1'b0;
    unique case (kind)
      SYM_ZERO:     viol_o = 1'b0;
      SYM_BAD_ZERO: viol_o = 1'b1;
      SYM_ONE:      viol_o = have_ref_q && (ref_lvl_q == first_h);
      default:      viol_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref_q <= 1'b0;
      ref_lvl_q  <= 1'b0;
    end else if (fire && kind == SYM_ONE) begin
      have_ref_q <= 1'b1;
      ref_lvl_q  <= first_h;
    end
  end

  // R6
  ref_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && first_h == second_h) |=> (have_ref_q && ref_lvl_q == $past(first_h)));
  // R5
  first_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_ref_q && first_h == second_h) |-> !viol_o);
endmodule

// File: rtl/cmi_out_stage.sv
module cmi_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic bit_i,
  input  logic viol_i,
  input  logic los,
  input  logic out_ready,
  output logic out_valid,
  output logic out_data,
  output logic out_viol
);
  logic valid_q, data_q, viol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= bit_i;
      viol_q  <= viol_i;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q & ~los;
  assign out_viol  = viol_q;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(data_q) && $stable(viol_q)));
endmodule

// File: rtl/cmi_line_decoder.sv
module cmi_line_decoder (
  input  logic clk,
  input  logic rst_n,
  input  logic cmi_en,
  input  logic los,
  input  logic smp_valid,
  output logic smp_ready,
  input  logic smp_data,
  output logic bit_valid,
  input  logic bit_ready,
  output logic bit_data,
  output logic bit_viol
);
  logic take, pair_fire, first_half;
  logic dec_bit, dec_viol;
  logic load, sel_bit, sel_viol;

  assign smp_ready = !bit_valid || bit_ready;
  assign take      = smp_valid && smp_ready;

  cmi_pair_collect pair_i (
    .clk(clk), .rst_n(rst_n), .cmi_en(cmi_en), .take(take),
    .sample(smp_data), .pair_fire(pair_fire), .first_half(first_half)
  );

  cmi_sym_judge judge_i (
    .clk(clk), .rst_n(rst_n), .fire(pair_fire), .first_h(first_half),
    .second_h(smp_data), .bit_o(dec_bit), .viol_o(dec_viol)
  );

  assign load     = cmi_en ? pair_fire : take;
  assign sel_bit  = cmi_en ? dec_bit  : smp_data;
  assign sel_viol = cmi_en ? dec_viol : 1'b0;

  cmi_out_stage out_i (
    .clk(clk), .rst_n(rst_n), .load(load), .bit_i(sel_bit), .viol_i(sel_viol),
    .los(los), .out_ready(bit_ready), .out_valid(bit_valid),
    .out_data(bit_data), .out_viol(bit_viol)
  );

  // R4
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_fire && first_half && !smp_data) |=> (bit_valid && bit_viol && (los || !bit_data)));
  // R8
  nrz_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmi_en) |=> (bit_valid && !bit_viol && (los || bit_data == $past(smp_data))));
  // R10
  no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |-> !take);
endmodule

// File: tb/cmi_line_decoder_tb.sv
module cmi_line_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n, cmi_en, los, smp_valid, smp_data, bit_ready;
  logic smp_ready, bit_valid, bit_data, bit_viol;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  cmi_line_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cmi_en(cmi_en), .los(los),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data), .bit_viol(bit_viol)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one sample, then an idle cycle; outputs checked one cycle after acceptance
  task automatic push(input logic s, input logic exp_v, input logic exp_b,
                      input logic exp_x, input string req);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = s;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(req, bit_valid, exp_v);
    if (exp_v) begin
      chk(req, bit_data, exp_b);
      chk(req, bit_viol, exp_x);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmi_en = 1'b1; los = 1'b0; smp_valid = 1'b0;
    smp_data = 1'b0; bit_ready = 1'b1;
    do_reset();
    // R1
    chk("R1 valid", bit_valid, 1'b0);
    chk("R1 ready", smp_ready, 1'b1);

    // Exhaustive CMI sweep: every sequence of four pairs (R2 R3 R4 R5 R6 R7)
    for (int code = 0; code < 256; code++) begin
      logic have_ref, ref_lvl;
      have_ref = 1'b0; ref_lvl = 1'b0;
      do_reset();
      for (int p = 0; p < 4; p++) begin
        logic a, b, eb, ex;
        a = code[2*p+1]; b = code[2*p];
        if (a == b) begin
          eb = 1'b1; ex = have_ref && (a == ref_lvl);
          have_ref = 1'b1; ref_lvl = a;
        end else begin
          eb = 1'b0; ex = a;
        end
        push(a, 1'b0, 1'b0, 1'b0, "R7 first half no output");
        push(b, 1'b1, eb, ex, "R2/R3/R4/R5/R6 pair decode");
      end
    end

    // Directed: single repeated one flags once (R6)
    do_reset();
    push(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    push(1'b1, 1'b1, 1'b1, 1'b0, "R5 first one");
    push(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    push(1'b1, 1'b1, 1'b1, 1'b1, "R3 repeat flagged");
    push(1'b0, 1'b0, 1'b0, 1'b0, "R7");
    push(1'b0, 1'b1, 1'b1, 1'b0, "R6 no error multiplication");

    // NRZ sweep (R8)
    cmi_en = 1'b0;
    for (int pat = 0; pat < 256; pat++) begin
      do_reset();
      for (int k = 0; k < 8; k++)
        push(pat[k], 1'b1, pat[k], 1'b0, "R8 pass-through");
    end

    // Stall and loss of signal (R9 R10)
    do_reset();
    bit_ready = 1'b0;
    push(1'b1, 1'b1, 1'b1, 1'b0, "R8 load before stall");
    chk("R10 ready low", smp_ready, 1'b0);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 held valid", bit_valid, 1'b1);
    chk("R10 held data", bit_data, 1'b1);
    los = 1'b1;
    #1 chk("R9 forced low", bit_data, 1'b0);
    chk("R9 valid kept", bit_valid, 1'b1);
    @(negedge clk);
    chk("R9 still low", bit_data, 1'b0);
    los = 1'b0;
    #1 chk("R9 released", bit_data, 1'b1);
    smp_valid = 1'b0;
    bit_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", bit_valid, 1'b0);
    push(1'b0, 1'b1, 1'b0, 1'b0, "R10 intake resumes");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule